// File: doc/BRIEF.md
# Effective Address Generator

This block works out the memory address an 8-bit processor instruction operates on. The processor's address bus is 16 bits wide. The decode stage supplies four things: a 4-bit addressing-mode code, the one or two operand bytes that follow the opcode, the two index registers and the stack pointer. It then pulses `start`. The block answers with a one-cycle `done` pulse. With it come the final address and a flag that says whether the mode names a memory location at all.

Some modes get their address straight from the inputs: absolute, absolute indexed, page-zero, page-zero indexed and stack. These finish in one cycle. Three modes go through a pointer: indexed-indirect, indirect-indexed and absolute indirect. For these, the block fetches a little-endian pointer word from memory. It does this through a simple read port with one cycle of latency. It issues the two byte reads on consecutive cycles and assembles the result. While a fetch is in progress the block reports `busy` and ignores `start`.

Top module: `eff_addr_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done`, `addr_valid`, `rd_req` and `busy` are 0 and `eff_addr` is 0x0000.
- R2: Mode codes 0, 1, 2 and 13 to 15 name no location. `start` with one of them gives `done`=1 in the next cycle, with `addr_valid`=0 and `eff_addr`=0x0000.
- R3: Mode 3 gives {hi,lo}. Mode 4 gives ({hi,lo}+X) mod 65536 and mode 5 gives ({hi,lo}+Y) mod 65536, so the carry reaches the high byte.
- R4: Modes 6, 7 and 8 give high byte 0x00. The low byte is lo, (lo+X) mod 256 or (lo+Y) mod 256 respectively, so the address never leaves page zero.
- R5: Mode 12 gives 0x0100 + stack pointer.
- R6: Modes 3 to 8 and 12 raise `done` and `addr_valid` in the cycle after `start` is accepted.
- R7: The pointer modes drive `rd_req` for exactly two consecutive cycles. The first cycle is the one after `start` and carries the pointer address. The second carries the pointer address plus one. `rd_data` is valid one cycle after each request. `done` with `addr_valid`=1 follows one cycle after the second byte arrives. The word is little-endian: low byte at the pointer, high byte at pointer+1.
- R8: In mode 9 the pointer is 0x00 : ((lo+X) mod 256), and pointer+1 also wraps inside page zero. The result is the fetched word.
- R9: In mode 10 the pointer is 0x00 : lo, and pointer+1 wraps inside page zero. The result is (word+Y) mod 65536, with Y taken when `start` was accepted.
- R10: In mode 11 the pointer is {hi,lo} and pointer+1 is a full 16-bit increment. The result is the fetched word.
- R11: While `busy` is 1, `start` has no effect: no extra read and no extra `done`. `busy` is 1 from the cycle after a pointer mode is accepted until its `done` cycle, where it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation |
| mode | input | 4 | Addressing-mode code |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| stk_ptr | input | 8 | Stack pointer |
| rd_data | input | 8 | Read data, one cycle after the request |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte read address |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | One-cycle result strobe |
| addr_valid | output | 1 | Result names a memory location |
| eff_addr | output | 16 | Effective address |

## Verification
The bench builds the block with its defaults: 8-bit data, a derived 16-bit address and the stack on page one. At these sizes every wrap boundary can be reached with short operand values. These include the 0xFF/0x00 page-zero edge, the 0xFFFF to 0x0000 roll of absolute indexing and of the absolute-indirect pointer, and a carry out of the indirect word. Directed cases hit those edges and start requests held during a fetch. Random mode codes, including the unused ones, then cover mixed back-to-back sequences against the clocked reference model.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    AM_IMM  = 4'd0,
    AM_IMPL = 4'd1,
    AM_ACC  = 4'd2,
    AM_ABS  = 4'd3,
    AM_ABSX = 4'd4,
    AM_ABSY = 4'd5,
    AM_ZP   = 4'd6,
    AM_ZPX  = 4'd7,
    AM_ZPY  = 4'd8,
    AM_XIND = 4'd9,
    AM_INDY = 4'd10,
    AM_IND  = 4'd11,
    AM_STK  = 4'd12
  } am_e;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_RD0  = 2'd1,
    PS_RD1  = 2'd2,
    PS_FIN  = 2'd3
  } pstate_e;

  function automatic logic is_ptr_mode(input logic [3:0] m);
    return (m == AM_XIND) || (m == AM_INDY) || (m == AM_IND);
  endfunction
endpackage

// File: rtl/eag_index_add.sv
module eag_index_add #(
  parameter int DATA_W    = 8,
  parameter bit WRAP_PAGE = 1'b0
) (
  input  logic [2*DATA_W-1:0] base,
  input  logic [DATA_W-1:0]   idx,
  output logic [2*DATA_W-1:0] sum
);
  localparam int AW = 2 * DATA_W;

  generate
    if (WRAP_PAGE) begin : g_wrap
      logic [DATA_W-1:0] lo_sum;
      always_comb lo_sum = base[DATA_W-1:0] + idx;
      assign sum = {base[AW-1:DATA_W], lo_sum};
    end else begin : g_carry
      assign sum = base + {{DATA_W{1'b0}}, idx};
    end
  endgenerate
endmodule

// File: rtl/eag_direct.sv
module eag_direct
  import eag_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STACK_PAGE = 1
) (
  input  logic [3:0]          mode,
  input  logic [DATA_W-1:0]   opnd_lo,
  input  logic [DATA_W-1:0]   opnd_hi,
  input  logic [DATA_W-1:0]   idx_x,
  input  logic [DATA_W-1:0]   idx_y,
  input  logic [DATA_W-1:0]   stk_ptr,
  output logic [2*DATA_W-1:0] addr,
  output logic                has_addr
);
  localparam int AW = 2 * DATA_W;
  localparam logic [DATA_W-1:0] STK_HI = DATA_W'(STACK_PAGE);

  logic [DATA_W-1:0] abs_idx, zp_idx;
  logic [AW-1:0]     abs_sum, zp_sum;

  always_comb begin
    abs_idx = (mode == AM_ABSY) ? idx_y : idx_x;
    case (mode)
      AM_ZPX:  zp_idx = idx_x;
      AM_ZPY:  zp_idx = idx_y;
      default: zp_idx = '0;
    endcase
  end

  eag_index_add #(.DATA_W(DATA_W), .WRAP_PAGE(1'b0)) u_abs_add (
    .base ({opnd_hi, opnd_lo}),
    .idx  (abs_idx),
    .sum  (abs_sum)
  );

  eag_index_add #(.DATA_W(DATA_W), .WRAP_PAGE(1'b1)) u_zp_add (
    .base ({{DATA_W{1'b0}}, opnd_lo}),
    .idx  (zp_idx),
    .sum  (zp_sum)
  );

  always_comb begin
    addr     = '0;
    has_addr = 1'b1;
    case (mode)
      AM_ABS:                 addr = {opnd_hi, opnd_lo};
      AM_ABSX, AM_ABSY:       addr = abs_sum;
      AM_ZP, AM_ZPX, AM_ZPY:  addr = zp_sum;
      AM_STK:                 addr = {STK_HI, stk_ptr};
      default:                has_addr = 1'b0;
    endcase
  end
endmodule

// File: rtl/eag_ptr_seq.sv
module eag_ptr_seq
  import eag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch,
  input  logic [3:0]          mode,
  input  logic [DATA_W-1:0]   opnd_lo,
  input  logic [DATA_W-1:0]   opnd_hi,
  input  logic [DATA_W-1:0]   idx_x,
  input  logic [DATA_W-1:0]   idx_y,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                rd_req,
  output logic [2*DATA_W-1:0] rd_addr,
  output logic                busy,
  output logic                fin,
  output logic [2*DATA_W-1:0] fin_addr
);
  localparam int AW = 2 * DATA_W;

  pstate_e           state;
  logic [AW-1:0]     ptr_q;
  logic              zp_q;
  logic [DATA_W-1:0] y_q;
  logic [DATA_W-1:0] lo_q;
  logic [AW-1:0]     ptr_first;
  logic [DATA_W-1:0] ptr_zp_lo;
  logic [AW-1:0]     ptr_next;

  always_comb begin
    ptr_zp_lo = opnd_lo + ((mode == AM_XIND) ? idx_x : '0);
    if (mode == AM_IND) ptr_first = {opnd_hi, opnd_lo};
    else                ptr_first = {{DATA_W{1'b0}}, ptr_zp_lo};
  end

  eag_index_add #(.DATA_W(DATA_W), .WRAP_PAGE(1'b1)) u_zp_inc (
    .base (ptr_q),
    .idx  (DATA_W'(1)),
    .sum  (ptr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PS_IDLE;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      ptr_q   <= '0;
      zp_q    <= 1'b0;
      y_q     <= '0;
      lo_q    <= '0;
    end else begin
      unique case (state)
        PS_IDLE: if (launch) begin
          state   <= PS_RD0;
          rd_req  <= 1'b1;
          rd_addr <= ptr_first;
          ptr_q   <= ptr_first;
          zp_q    <= (mode != AM_IND);
          y_q     <= (mode == AM_INDY) ? idx_y : '0;
        end
        PS_RD0: begin
          state   <= PS_RD1;
          rd_addr <= zp_q ? ptr_next : ptr_q + AW'(1);
        end
        PS_RD1: begin
          state  <= PS_FIN;
          rd_req <= 1'b0;
          lo_q   <= rd_data;
        end
        PS_FIN: state <= PS_IDLE;
      endcase
    end
  end

  eag_index_add #(.DATA_W(DATA_W), .WRAP_PAGE(1'b0)) u_word_add (
    .base ({rd_data, lo_q}),
    .idx  (y_q),
    .sum  (fin_addr)
  );

  assign busy = (state != PS_IDLE);
  assign fin  = (state == PS_FIN);
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STACK_PAGE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [DATA_W-1:0] opnd_lo,
  input  logic [DATA_W-1:0] opnd_hi,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  input  logic [DATA_W-1:0] stk_ptr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_req,
  output logic [2*DATA_W-1:0] rd_addr,
  output logic              busy,
  output logic              done,
  output logic              addr_valid,
  output logic [2*DATA_W-1:0] eff_addr
);
  localparam int AW = 2 * DATA_W;

  logic          accept, ptr_sel;
  logic [AW-1:0] dir_addr, seq_addr;
  logic          dir_has, seq_fin;

  assign accept  = start & ~busy;
  assign ptr_sel = is_ptr_mode(mode);

  eag_direct #(.DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE)) u_direct (
    .mode     (mode),
    .opnd_lo  (opnd_lo),
    .opnd_hi  (opnd_hi),
    .idx_x    (idx_x),
    .idx_y    (idx_y),
    .stk_ptr  (stk_ptr),
    .addr     (dir_addr),
    .has_addr (dir_has)
  );

  eag_ptr_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .launch   (accept & ptr_sel),
    .mode     (mode),
    .opnd_lo  (opnd_lo),
    .opnd_hi  (opnd_hi),
    .idx_x    (idx_x),
    .idx_y    (idx_y),
    .rd_data  (rd_data),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .busy     (busy),
    .fin      (seq_fin),
    .fin_addr (seq_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      addr_valid <= 1'b0;
      eff_addr   <= '0;
    end else if (accept && !ptr_sel) begin
      done       <= 1'b1;
      addr_valid <= dir_has;
      eff_addr   <= dir_has ? dir_addr : '0;
    end else if (seq_fin) begin
      done       <= 1'b1;
      addr_valid <= 1'b1;
      eff_addr   <= seq_addr;
    end else begin
      done       <= 1'b0;
      addr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/eag_chk.sv
module eag_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [3:0] mode,
  input logic       busy,
  input logic       done,
  input logic       addr_valid,
  input logic       rd_req,
  input logic [7:0] eff_hi
);
  // R7
  rd_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |=> rd_req);

  // R7
  rd_len_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && $past(rd_req)) |=> !rd_req);

  // R2
  valid_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> done);

  // R11
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6
  direct_done_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && start && !busy && mode != 4'd9 && mode != 4'd10 && mode != 4'd11)
      |-> done);

  // R5
  stack_page_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && start && !busy && mode == 4'd12) |-> (addr_valid && eff_hi == 8'h01));

  // R4
  zero_page_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && start && !busy && (mode == 4'd6 || mode == 4'd7 || mode == 4'd8))
      |-> (addr_valid && eff_hi == 8'h00));
endmodule

bind eff_addr_gen eag_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .mode       (mode),
  .busy       (busy),
  .done       (done),
  .addr_valid (addr_valid),
  .rd_req     (rd_req),
  .eff_hi     (eff_addr[15:8])
);

// File: tb/sim_eff_addr_gen.sv
`timescale 1ns/1ps
module sim_eff_addr_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic [7:0] opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0, stk_ptr = '0;
  logic [7:0] rd_data = '0;
  logic rd_req, busy, done, addr_valid;
  logic [15:0] rd_addr, eff_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  eff_addr_gen u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
    .stk_ptr(stk_ptr), .rd_data(rd_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .busy(busy), .done(done), .addr_valid(addr_valid), .eff_addr(eff_addr)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h6B;
  endfunction

  // memory with one cycle of read latency
  always @(posedge clk) rd_data <= rd_req ? memf(rd_addr) : 8'hEE;

  // reference model
  int          m_phase = 0;
  logic        m_req = 0, m_done = 0, m_valid = 0, m_rst = 1;
  logic [15:0] m_raddr = 0, m_eff = 0, m_ptr = 0, m_ptr1 = 0;
  logic        m_zp = 0;
  logic [7:0]  m_y = 0, m_lo = 0;
  string       m_tag = "R1";

  always @(posedge clk) begin
    m_rst = rst;
    if (rst) begin
      m_phase = 0; m_req = 0; m_done = 0; m_valid = 0; m_eff = 0; m_raddr = 0;
    end else begin
      m_done = 0; m_valid = 0;
      case (m_phase)
        0: if (start) begin
          case (int'(mode))
            3:  begin m_done = 1; m_valid = 1; m_eff = {opnd_hi, opnd_lo}; m_tag = "R3 R6"; end
            4:  begin m_done = 1; m_valid = 1; m_eff = 16'(({opnd_hi, opnd_lo} + idx_x) % 65536); m_tag = "R3 R6"; end
            5:  begin m_done = 1; m_valid = 1; m_eff = 16'(({opnd_hi, opnd_lo} + idx_y) % 65536); m_tag = "R3 R6"; end
            6:  begin m_done = 1; m_valid = 1; m_eff = {8'h00, opnd_lo}; m_tag = "R4 R6"; end
            7:  begin m_done = 1; m_valid = 1; m_eff = 16'((opnd_lo + idx_x) % 256); m_tag = "R4 R6"; end
            8:  begin m_done = 1; m_valid = 1; m_eff = 16'((opnd_lo + idx_y) % 256); m_tag = "R4 R6"; end
            12: begin m_done = 1; m_valid = 1; m_eff = 16'(256 + stk_ptr); m_tag = "R5 R6"; end
            9, 10, 11: begin
              m_phase = 1; m_req = 1;
              if (mode == 4'd9)       begin m_ptr = 16'((opnd_lo + idx_x) % 256); m_zp = 1; m_y = 0; m_tag = "R8 R7"; end
              else if (mode == 4'd10) begin m_ptr = {8'h00, opnd_lo}; m_zp = 1; m_y = idx_y; m_tag = "R9 R7"; end
              else                    begin m_ptr = {opnd_hi, opnd_lo}; m_zp = 0; m_y = 0; m_tag = "R10 R7"; end
              m_ptr1 = m_zp ? {8'h00, 8'(m_ptr[7:0] + 1)} : 16'(m_ptr + 1);
              m_raddr = m_ptr;
            end
            default: begin m_done = 1; m_valid = 0; m_eff = 0; m_tag = "R2"; end
          endcase
        end
        1: begin m_phase = 2; m_raddr = m_ptr1; end
        2: begin m_phase = 3; m_req = 0; m_lo = memf(m_ptr); end
        default: begin
          m_phase = 0; m_done = 1; m_valid = 1;
          m_eff = 16'(({memf(m_ptr1), m_lo} + m_y) % 65536);
        end
      endcase
    end
  end

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (m_rst) begin
      chk("R1", "done", 16'(done), 16'(m_done));
      chk("R1", "rd_req", 16'(rd_req), 16'(m_req));
      chk("R1", "eff_addr", eff_addr, 16'h0000);
      chk("R1", "busy", 16'(busy), 16'd0);
    end else begin
      chk(m_phase != 0 ? "R11" : m_tag, "done", 16'(done), 16'(m_done));
      chk(m_tag, "addr_valid", 16'(addr_valid), 16'(m_valid));
      chk("R11", "busy", 16'(busy), 16'(m_phase != 0));
      chk("R7", "rd_req", 16'(rd_req), 16'(m_req));
      if (m_req) chk(m_tag, "rd_addr", rd_addr, m_raddr);
      if (m_done) chk(m_tag, "eff_addr", eff_addr, m_eff);
    end
  end

  task automatic op(input int md, input int lo, input int hi, input int x, input int y, input int sp);
    @(negedge clk);
    mode = 4'(md); opnd_lo = 8'(lo); opnd_hi = 8'(hi);
    idx_x = 8'(x); idx_y = 8'(y); stk_ptr = 8'(sp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (md >= 9 && md <= 11) repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 no-address modes
    op(0, 8'h12, 8'h34, 1, 2, 3);
    op(1, 0, 0, 0, 0, 0);
    op(2, 0, 0, 0, 0, 0);
    op(14, 5, 5, 5, 5, 5);
    // R3 absolute and carry into high byte
    op(3, 8'hCD, 8'hAB, 0, 0, 0);
    op(4, 8'hFF, 8'h12, 1, 0, 0);
    op(5, 8'hF0, 8'hFF, 0, 8'h20, 0);
    // R4 page-zero wrap
    op(6, 8'h81, 8'h77, 0, 0, 0);
    op(7, 8'hF0, 8'h99, 8'h20, 0, 0);
    op(8, 8'hFF, 8'h99, 0, 8'hFF, 0);
    // R5 stack
    op(12, 0, 0, 0, 0, 8'hFF);
    op(12, 0, 0, 0, 0, 8'h00);
    // R8 indexed-indirect, pointer at 0xFF wraps to 0x00
    op(9, 8'hF0, 8'h55, 8'h0F, 0, 0);
    op(9, 8'h10, 0, 8'h05, 0, 0);
    // R9 indirect-indexed with carry
    op(10, 8'hFF, 0, 0, 8'hFF, 0);
    op(10, 8'h40, 0, 0, 8'h01, 0);
    // R10 absolute indirect, pointer at 0xFFFF rolls to 0x0000
    op(11, 8'hFF, 8'hFF, 0, 0, 0);
    op(11, 8'h34, 8'h12, 0, 0, 0);
    // R11 start held high during a fetch
    @(negedge clk);
    mode = 4'd10; opnd_lo = 8'h22; idx_y = 8'h80; start = 1'b1;
    @(negedge clk);
    mode = 4'd3; opnd_lo = 8'h01; opnd_hi = 8'h02;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    // R6 back-to-back direct requests
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      mode = 4'(3 + (i % 6)); opnd_lo = 8'(i * 37); opnd_hi = 8'(255 - i);
      idx_x = 8'(i * 90); idx_y = 8'(i * 71); start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    // random mix
    for (int i = 0; i < 400; i++)
      op(int'($urandom % 16), int'($urandom % 256), int'($urandom % 256),
         int'($urandom % 256), int'($urandom % 256), int'($urandom % 256));
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule